// File: doc/BRIEF.md
# Banked SRAM Address and Enable Mapper

This block sits between a 32-bit word-addressed request port and an external asynchronous SRAM array built from one to four banks of identical size. A three-bit size code, taken from bits 23 to 21 of a configuration word, gives the depth of every bank. The block places the two bank-select bits directly above the in-bank word offset, so the populated banks form one unbroken address space. It drives the SRAM address, one active-low chip select per bank, an active-low output enable, four active-low byte strobes and the write data with its drive enable.

A mode pin picks the device type. Low selects narrow parts (x4 or x8), where the strobes act as write strobes only. High selects x16 parts, where the strobes become byte enables and are asserted on reads as well as writes. Every read returns the full 32-bit word, whatever the lanes requested. One access is in flight at a time. It lasts a fixed number of cycles and ends with a one-cycle done pulse. A bank select beyond the populated banks is refused with an error pulse and no chip select.

Top module: `sram_bank_mapper`

## Requirements
- R1: The size code sets the in-bank word-offset width w: code 0 gives 20 bits, code 1 gives 21 bits, and codes 2 to 7 give code+12 bits (16K to 512K words). The code is sampled when a request is accepted.
- R2: During an access, sram_addr equals (bank << w) | (offset mod 2^w). Offset bits at or above w have no effect on the address.
- R3: For an accepted request with bank below NUM_BANKS, only sram_cs_n[bank] is low. It stays low for exactly ACC_CYCLES cycles, starting the cycle after acceptance, and sram_addr holds steady over that time.
- R4: A request whose bank is NUM_BANKS or more asserts no chip select, no strobe and no output enable. The cycle after acceptance, err and done are both high for one cycle.
- R5: A write in narrow mode (x16_mode low) drives sram_we_n = ~req_be, keeps sram_oe_n high, and drives sram_dq_o = req_wdata with sram_dq_oe high. Strobe bit i covers data bits 8i+7:8i.
- R6: A read in narrow mode holds all four sram_we_n bits high, drives sram_oe_n low and keeps sram_dq_oe low.
- R7: A read in x16 mode drives all four sram_we_n bits low as byte enables, together with sram_oe_n low.
- R8: A write in x16 mode drives sram_we_n = ~req_be with sram_oe_n high.
- R9: The cycle after the last access cycle, done is high for one cycle. For a read, rdata then holds the full 32-bit sram_dq_i word from that last cycle, regardless of req_be.
- R10: req_ready is low from acceptance to the end of the access. A request presented while req_ready is low is not taken and does not disturb the access in progress. It is accepted once req_ready returns high.
- R11: While and after reset: req_ready high, all chip selects, strobes and output enable high, done and err low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size | input | 3 | Bank size code (configuration bits 23:21) |
| x16_mode | input | 1 | 0: x4/x8 parts, 1: x16 parts with byte enables |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 write, 0 read |
| req_bank | input | 2 | Bank select |
| req_offset | input | 21 | Word offset inside the bank |
| req_be | input | 4 | Byte lanes of a write |
| req_wdata | input | 32 | Write data |
| done | output | 1 | One-cycle end-of-access pulse |
| err | output | 1 | One-cycle pulse for an unpopulated bank |
| rdata | output | 32 | Read word |
| sram_addr | output | 23 | SRAM word address |
| sram_cs_n | output | 4 | Active-low chip select per bank |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 4 | Active-low write strobes / byte enables |
| sram_dq_o | output | 32 | Data to SRAM |
| sram_dq_oe | output | 1 | Data drive enable |
| sram_dq_i | input | 32 | Data from SRAM |

## Verification
The strobe properties compare the outputs against the live mode pin. They therefore assume x16_mode is held steady during an access, and the stimulus changes it only between accesses while the block is idle. The request fields are assumed to matter only while req_valid is high. The bench sweeps every size code, bank, mode and direction with offsets that set bits above the bank width, and it exercises a request held off during a busy access.

// File: rtl/sram_map_pkg.sv
package sram_map_pkg;

    localparam int DATA_W   = 32;
    localparam int LANES    = DATA_W / 8;
    localparam int BANK_W   = 2;
    localparam int MAX_CS   = 1 << BANK_W;
    localparam int OFS_W    = 21;
    localparam int ADDR_W   = OFS_W + BANK_W;
    localparam int CODE_W   = 3;
    localparam int SPAN_W   = 5;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic              write;
        logic [BANK_W-1:0] bank;
        logic [OFS_W-1:0]  offset;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
        logic [CODE_W-1:0] code;
    } mem_req_t;

    typedef struct packed {
        logic [MAX_CS-1:0] cs_n;
        logic              oe_n;
        logic [LANES-1:0]  we_n;
        logic              dq_oe;
    } pin_ctl_t;

    // Width of the in-bank word offset for a size code (non-monotonic map)
    function automatic logic [SPAN_W-1:0] span_bits(input logic [CODE_W-1:0] code);
        case (code)
            3'b000:  return SPAN_W'(20);
            3'b001:  return SPAN_W'(21);
            default: return SPAN_W'(code) + SPAN_W'(12);
        endcase
    endfunction

endpackage

// File: rtl/sbm_addr_map.sv
module sbm_addr_map
    import sram_map_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [BANK_W-1:0] bank,
    input  logic [OFS_W-1:0]  offset,
    output logic [ADDR_W-1:0] addr
);
    logic [SPAN_W-1:0] width;
    logic [OFS_W-1:0]  keep;

    assign width = span_bits(code);
    // 1<<21 wraps to zero in OFS_W bits, so the mask becomes all ones
    assign keep  = (OFS_W'(1) << width) - OFS_W'(1);
    assign addr  = (ADDR_W'(bank) << width) | ADDR_W'(offset & keep);
endmodule

// File: rtl/sbm_strobe_gen.sv
module sbm_strobe_gen
    import sram_map_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic              active,
    input  logic              x16_mode,
    input  mem_req_t          cur,
    output pin_ctl_t          ctl
);
    always_comb begin
        ctl.oe_n  = 1'b1;
        ctl.we_n  = '1;
        ctl.dq_oe = 1'b0;
        if (active) begin
            if (cur.write) begin
                ctl.we_n  = ~cur.be;
                ctl.dq_oe = 1'b1;
            end else begin
                ctl.oe_n = 1'b0;
                ctl.we_n = x16_mode ? '0 : '1;
            end
        end
    end

    for (genvar b = 0; b < MAX_CS; b++) begin : g_cs
        if (b < NUM_BANKS) begin : g_pop
            assign ctl.cs_n[b] = !(active && (int'(cur.bank) == b));
        end else begin : g_empty
            assign ctl.cs_n[b] = 1'b1;
        end
    end
endmodule

// File: rtl/sbm_seq.sv
module sbm_seq
    import sram_map_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int ACC_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  mem_req_t          req_in,
    input  logic [DATA_W-1:0] dq_in,
    output logic              ready,
    output logic              active,
    output mem_req_t          cur,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata
);
    localparam int CNT_W = (ACC_CYCLES > 1) ? $clog2(ACC_CYCLES) : 1;

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;

    assign ready  = (state == ST_IDLE);
    assign active = (state == ST_ACCESS);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            cur   <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
            rdata <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (int'(req_in.bank) < NUM_BANKS) begin
                            cur   <= req_in;
                            cnt   <= CNT_W'(ACC_CYCLES - 1);
                            state <= ST_ACCESS;
                        end else begin
                            done <= 1'b1;
                            err  <= 1'b1;
                        end
                    end
                end
                ST_ACCESS: begin
                    if (cnt == '0) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                        if (!cur.write) rdata <= dq_in;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sram_bank_mapper.sv
module sram_bank_mapper
    import sram_map_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int ACC_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_size,
    input  logic              x16_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_bank,
    input  logic [20:0]       req_offset,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              done,
    output logic              err,
    output logic [31:0]       rdata,
    output logic [22:0]       sram_addr,
    output logic [3:0]        sram_cs_n,
    output logic              sram_oe_n,
    output logic [3:0]        sram_we_n,
    output logic [31:0]       sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [31:0]       sram_dq_i
);
    mem_req_t req_in, cur;
    pin_ctl_t ctl;
    logic     active;

    assign req_in = '{write: req_write, bank: req_bank, offset: req_offset,
                      be: req_be, wdata: req_wdata, code: cfg_size};

    sbm_seq #(.NUM_BANKS(NUM_BANKS), .ACC_CYCLES(ACC_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_in(req_in),
        .dq_in(sram_dq_i), .ready(req_ready), .active(active), .cur(cur),
        .done(done), .err(err), .rdata(rdata)
    );

    sbm_addr_map u_map (
        .code(cur.code), .bank(cur.bank), .offset(cur.offset), .addr(sram_addr)
    );

    sbm_strobe_gen #(.NUM_BANKS(NUM_BANKS)) u_strb (
        .active(active), .x16_mode(x16_mode), .cur(cur), .ctl(ctl)
    );

    assign sram_cs_n  = ctl.cs_n;
    assign sram_oe_n  = ctl.oe_n;
    assign sram_we_n  = ctl.we_n;
    assign sram_dq_oe = ctl.dq_oe;
    assign sram_dq_o  = cur.wdata;
endmodule

// File: rtl/sram_bank_mapper_chk.sv
module sram_bank_mapper_chk #(
    parameter int NUM_BANKS = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        x16_mode,
    input logic        req_valid,
    input logic        req_ready,
    input logic [1:0]  req_bank,
    input logic        done,
    input logic        err,
    input logic [22:0] sram_addr,
    input logic [3:0]  sram_cs_n,
    input logic        sram_oe_n,
    input logic [3:0]  sram_we_n,
    input logic        sram_dq_oe
);
    p_cs_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~sram_cs_n));

    p_addr_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !sram_cs_n[0] || !req_ready && sram_cs_n != 4'hF) && $past(!req_ready)
        |-> $stable(sram_addr));

    p_bad_bank_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && int'(req_bank) >= NUM_BANKS)
        |=> (err && done && sram_cs_n == 4'hF && sram_oe_n && sram_we_n == 4'hF));

    p_err_done_r4: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    p_narrow_write_r5: assert property (@(posedge clk) disable iff (rst)
        (!x16_mode && sram_we_n != 4'hF) |-> (sram_oe_n && sram_dq_oe));

    p_narrow_read_r6: assert property (@(posedge clk) disable iff (rst)
        (!x16_mode && !sram_oe_n) |-> (sram_we_n == 4'hF && !sram_dq_oe));

    p_x16_read_r7: assert property (@(posedge clk) disable iff (rst)
        (x16_mode && !sram_oe_n) |-> (sram_we_n == 4'h0));

    p_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (sram_cs_n != 4'hF) |-> !req_ready);
endmodule

bind sram_bank_mapper sram_bank_mapper_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk(clk), .rst(rst), .x16_mode(x16_mode), .req_valid(req_valid),
    .req_ready(req_ready), .req_bank(req_bank), .done(done), .err(err),
    .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_dq_oe(sram_dq_oe)
);

// File: tb/sram_bank_mapper_bench.sv
`timescale 1ns/1ps
module sram_bank_mapper_bench;
    localparam int NB  = 3;
    localparam int ACC = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_size = '0;
    logic        x16_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [20:0] req_offset = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        done, err;
    logic [31:0] rdata;
    logic [22:0] sram_addr;
    logic [3:0]  sram_cs_n;
    logic        sram_oe_n;
    logic [3:0]  sram_we_n;
    logic [31:0] sram_dq_o;
    logic        sram_dq_oe;
    logic [31:0] sram_dq_i = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sram_bank_mapper #(.NUM_BANKS(NB), .ACC_CYCLES(ACC)) u_sram_bank_mapper (
        .clk(clk), .rst(rst), .cfg_size(cfg_size), .x16_mode(x16_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_offset(req_offset), .req_be(req_be),
        .req_wdata(req_wdata), .done(done), .err(err), .rdata(rdata),
        .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
        .sram_dq_i(sram_dq_i)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int span_of(input int code);
        if (code == 0) return 20;
        if (code == 1) return 21;
        return code + 12;
    endfunction

    function automatic logic [22:0] exp_addr(input int code, input int bank, input logic [20:0] off);
        int w = span_of(code);
        longint m = (64'd1 << w) - 1;
        return 23'((longint'(bank) << w) | (longint'(off) & m));
    endfunction

    // One request; drives at negedge, samples at negedges after each edge
    task automatic access(input int code, input int bank, input bit x16, input bit wr,
                          input logic [20:0] off, input logic [3:0] be,
                          input logic [31:0] wd, input logic [31:0] rpat);
        logic [22:0] ea;
        logic [3:0]  ecs;
        logic [3:0]  ewe;
        @(negedge clk);
        cfg_size = 3'(code); x16_mode = x16; req_write = wr; req_bank = 2'(bank);
        req_offset = off; req_be = be; req_wdata = wd; req_valid = 1'b1;
        chk(req_ready == 1'b1, "R10 idle ready", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_size = 3'(code + 3);   // later change must not affect the access (R1)
        if (bank >= NB) begin
            chk(done && err, "R4 err+done pulse", {done, err}, 2'b11);
            chk(sram_cs_n == 4'hF && sram_we_n == 4'hF && sram_oe_n,
                "R4 no select", {sram_cs_n, sram_we_n, sram_oe_n}, 9'h1FF);
            return;
        end
        ea  = exp_addr(code, bank, off);
        ecs = ~(4'b1 << bank);
        ewe = wr ? ~be : (x16 ? 4'h0 : 4'hF);
        for (int i = 0; i < ACC; i++) begin
            chk(sram_addr == ea, "R1 R2 address", sram_addr, ea);
            chk(sram_cs_n == ecs, "R3 chip select", sram_cs_n, ecs);
            chk(!req_ready, "R10 busy", req_ready, 0);
            if (wr) begin
                chk(sram_we_n == ewe && sram_oe_n && sram_dq_oe,
                    x16 ? "R8 x16 write" : "R5 narrow write",
                    {sram_we_n, sram_oe_n, sram_dq_oe}, {ewe, 2'b11});
                chk(sram_dq_o == wd, "R5 write data", sram_dq_o, wd);
            end else begin
                chk(sram_we_n == ewe && !sram_oe_n && !sram_dq_oe,
                    x16 ? "R7 x16 read" : "R6 narrow read",
                    {sram_we_n, sram_oe_n, sram_dq_oe}, {ewe, 2'b00});
            end
            sram_dq_i = (i == ACC - 1) ? rpat : ~rpat;
            @(negedge clk);
        end
        chk(done && !err, "R9 done pulse", {done, err}, 2'b10);
        chk(sram_cs_n == 4'hF, "R3 select released", sram_cs_n, 4'hF);
        if (!wr) chk(rdata == rpat, "R9 full read word", rdata, rpat);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && sram_cs_n == 4'hF && sram_we_n == 4'hF && sram_oe_n && !done && !err,
            "R11 in reset", {req_ready, sram_cs_n, sram_we_n, sram_oe_n, done, err}, 13'h1FFC);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && sram_cs_n == 4'hF && sram_we_n == 4'hF && sram_oe_n && !done && !err,
            "R11 after reset", {req_ready, sram_cs_n, sram_we_n, sram_oe_n, done, err}, 13'h1FFC);

        for (int code = 0; code < 8; code++)
            for (int bank = 0; bank < 4; bank++)
                for (int x = 0; x < 2; x++)
                    for (int wr = 0; wr < 2; wr++) begin
                        logic [20:0] off = 21'((32'h13579B * (code + 1)) ^ (bank * 32'h2468) ^ (x * 32'h5));
                        logic [3:0]  be  = 4'(code * 3 + bank + wr * 5 + x);
                        access(code, bank, x[0], wr[0], off, be,
                               32'hC0DE_0000 ^ 32'(code * 64 + bank * 8 + x * 2 + wr),
                               32'hA5A5_5A00 ^ 32'(code * 16 + bank));
                    end

        // Full-width offset boundary at the largest and smallest banks
        access(1, 2, 1'b0, 1'b0, 21'h1F_FFFF, 4'h1, 32'h0, 32'hFFFF_0001);
        access(2, 1, 1'b1, 1'b1, 21'h1F_FFFF, 4'h0, 32'h1234_5678, 32'h0);

        // R10: request held off while busy, taken once ready returns
        @(negedge clk);
        cfg_size = 3'd4; x16_mode = 1'b0; req_write = 1'b0; req_bank = 2'd0;
        req_offset = 21'h00_0ABC; req_valid = 1'b1;
        @(negedge clk);
        req_bank = 2'd2; req_offset = 21'h00_0123;
        chk(!req_ready && sram_cs_n == 4'b1110, "R10 held off 1", sram_cs_n, 4'b1110);
        @(negedge clk);
        chk(sram_cs_n == 4'b1110 && sram_addr == exp_addr(4, 0, 21'h00_0ABC),
            "R10 held off 2", sram_addr, exp_addr(4, 0, 21'h00_0ABC));
        @(negedge clk);
        chk(done && req_ready, "R10 ready after done", {done, req_ready}, 2'b11);
        @(negedge clk);
        req_valid = 1'b0;
        chk(sram_cs_n == 4'b1011 && sram_addr == exp_addr(4, 2, 21'h00_0123),
            "R10 pending taken", sram_addr, exp_addr(4, 2, 21'h00_0123));
        repeat (ACC + 1) @(negedge clk);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule